// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block holds the character queues between a UART's serial engines and the rest of the chip. The receive side accepts characters from the deserializer into a 16-entry queue. The transmit side buffers characters written by the host until the serializer pulls them. One control word sets everything: it turns queueing on or off, clears either queue on its own, picks a receive threshold, and chooses between request-driven and polled service.

Two service events come from the queue state. The receive-level event fires when receive occupancy reaches the programmed threshold. The transmit-room event fires while the transmit queue can take another character. The same events feed the request outputs, which an interrupt controller or a DMA engine can consume. Those outputs stay low in polled service, and the host then reads the status outputs instead.

A character that arrives while the receive queue is full is dropped, and a sticky overrun flag is raised. When queueing is turned off, each direction behaves as a single holding register.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After synchronous reset both queues are empty, queueing is off, request service is off, the threshold code is 0 and `rx_overrun` is low.
- R2: With queueing on, each direction returns characters in arrival order. `*_count` reports occupancy, and `*_full` is high at 16 entries.
- R3: A receive character offered while the receive queue is full, with no pop in the same cycle, is discarded and sets `rx_overrun`. The flag stays set until the receive queue is cleared.
- R4: With queueing on, the 2-bit threshold code in control bits [7:6] selects 1, 4, 8 or 14 entries for codes 0, 1, 2 and 3. `rx_level` is high exactly when `rx_count` is at or above the selected threshold.
- R5: `tx_room` is high exactly when the transmit queue is not full.
- R6: `rx_req` and `tx_req` follow `rx_level` and `tx_room` when control bit 3 (request service) is 1. They are held low when that bit is 0.
- R7: A control write with bit 1 set empties only the receive queue and clears `rx_overrun`. A write with bit 2 set empties only the transmit queue.
- R8: Clear bits act once per write and are not retained. A character pushed on the cycle after a clear write is kept.
- R9: Changing control bit 0 (queue enable) empties both queues. With bit 0 low, each direction holds one character: `*_full` is high at one entry and `rx_level` is high at one entry whatever the threshold code.
- R10: When a pop and a push occur in the same cycle on a full receive queue, the oldest character leaves, the new one is stored, the count stays at 16 and no overrun is flagged.
- R11: Control bits [5:4] are ignored. A write that keeps bit 0 unchanged and has bits 1 and 2 low leaves queue contents untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: [0] enable, [1] rx clear, [2] tx clear, [3] request service, [7:6] threshold code |
| rx_char_valid | input | 1 | Deserializer offers a character |
| rx_char | input | 8 | Received character |
| rx_pop | input | 1 | Host removes the oldest receive character |
| rx_data | output | 8 | Oldest receive character (0 when empty) |
| rx_count | output | 5 | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_level | output | 1 | Receive threshold reached |
| rx_req | output | 1 | Receive service request |
| tx_push | input | 1 | Host writes a transmit character |
| tx_wdata | input | 8 | Transmit character |
| tx_pop | input | 1 | Serializer takes the oldest transmit character |
| tx_data | output | 8 | Oldest transmit character (0 when empty) |
| tx_count | output | 5 | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_room | output | 1 | Transmit queue can accept a character |
| tx_req | output | 1 | Transmit service request |

## Verification
The receive queue is filled to each threshold code's boundary, one entry below and at the level. This separates a correct threshold from an off-by-one or a swapped code. It is then filled past capacity, which shows whether the extra character is dropped and flagged or overwrites stored data. Separate clears with the other queue loaded show that each clear reaches only its own direction. A push on the cycle after a clear shows that the clear bit does not persist. Toggling request service while the events are high, then dropping to single-register mode, separates event gating and the one-entry capacity from the normal path.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int CFG_W = 8;

    // Control word layout, MSB first
    typedef struct packed {
        logic [1:0] trig;
        logic [1:0] spare;
        logic       req_mode;
        logic       tx_clr;
        logic       rx_clr;
        logic       en;
    } fifo_cfg_t;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_NEAR    = 2'd3
    } trig_code_e;

    // Threshold in entries for a code, scaled to the queue depth
    function automatic int trig_entries(input logic [1:0] code, input int depth);
        case (trig_code_e'(code))
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output logic             en,
    output logic             req_mode,
    output logic [1:0]       trig,
    output logic             rx_flush,
    output logic             tx_flush
);
    fifo_cfg_t w;
    logic      en_q;
    logic      req_q;
    logic [1:0] trig_q;
    logic      en_change;

    assign w = fifo_cfg_t'(wdata);
    assign en_change = wr && (w.en != en_q);

    // Clear strobes exist only during the write cycle
    assign rx_flush = (wr && w.rx_clr) || en_change;
    assign tx_flush = (wr && w.tx_clr) || en_change;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            req_q  <= 1'b0;
            trig_q <= 2'd0;
        end else if (wr) begin
            en_q   <= w.en;
            req_q  <= w.req_mode;
            trig_q <= w.trig;
        end
    end

    assign en       = en_q;
    assign req_mode = req_q;
    assign trig     = trig_q;
endmodule

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cap;
    logic          do_push;
    logic          do_pop;

    assign cap     = single ? CW'(1) : CW'(DEPTH);
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q >= cap);
    assign do_pop  = pop && !empty;
    assign do_push = push && !flush && (!full || do_pop);
    assign drop    = push && !flush && !do_push;
    assign count   = cnt_q;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/uart_fifo_events.sv
module uart_fifo_events
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          en,
    input  logic          req_mode,
    input  logic [1:0]    trig,
    input  logic [CW-1:0] rx_count,
    input  logic          tx_full,
    output logic          rx_level,
    output logic          tx_room,
    output logic          rx_req,
    output logic          tx_req
);
    logic [CW-1:0] thr;

    always_comb begin
        if (en) thr = CW'(trig_entries(trig, DEPTH));
        else    thr = CW'(1);
    end

    assign rx_level = (rx_count >= thr);
    assign tx_room  = !tx_full;
    assign rx_req   = req_mode && rx_level;
    assign tx_req   = req_mode && tx_room;
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rx_char_valid,
    input  logic [W-1:0]     rx_char,
    input  logic             rx_pop,
    output logic [W-1:0]     rx_data,
    output logic [CW-1:0]    rx_count,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_overrun,
    output logic             rx_level,
    output logic             rx_req,
    input  logic             tx_push,
    input  logic [W-1:0]     tx_wdata,
    input  logic             tx_pop,
    output logic [W-1:0]     tx_data,
    output logic [CW-1:0]    tx_count,
    output logic             tx_empty,
    output logic             tx_full,
    output logic             tx_room,
    output logic             tx_req
);
    logic       en;
    logic       req_mode;
    logic [1:0] trig;
    logic       rx_flush;
    logic       tx_flush;
    logic       rx_drop;
    logic       tx_drop;
    logic       ovr_q;

    uart_fifo_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .en       (en),
        .req_mode (req_mode),
        .trig     (trig),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    uart_sync_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
        .clk    (clk),
        .rst    (rst),
        .flush  (rx_flush),
        .single (!en),
        .push   (rx_char_valid),
        .wdata  (rx_char),
        .pop    (rx_pop),
        .rdata  (rx_data),
        .count  (rx_count),
        .empty  (rx_empty),
        .full   (rx_full),
        .drop   (rx_drop)
    );

    uart_sync_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
        .clk    (clk),
        .rst    (rst),
        .flush  (tx_flush),
        .single (!en),
        .push   (tx_push),
        .wdata  (tx_wdata),
        .pop    (tx_pop),
        .rdata  (tx_data),
        .count  (tx_count),
        .empty  (tx_empty),
        .full   (tx_full),
        .drop   (tx_drop)
    );

    uart_fifo_events #(.DEPTH(DEPTH)) u_evt (
        .en       (en),
        .req_mode (req_mode),
        .trig     (trig),
        .rx_count (rx_count),
        .tx_full  (tx_full),
        .rx_level (rx_level),
        .tx_room  (tx_room),
        .rx_req   (rx_req),
        .tx_req   (tx_req)
    );

    // Sticky overrun; a receive flush wins over a new drop
    always_ff @(posedge clk) begin
        if (rst || rx_flush) ovr_q <= 1'b0;
        else if (rx_drop)    ovr_q <= 1'b1;
    end

    assign rx_overrun = ovr_q;
endmodule

// File: rtl/uart_fifo_chk.sv
module uart_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic [7:0]    cfg_wdata,
    input logic          rx_char_valid,
    input logic          rx_pop,
    input logic [CW-1:0] rx_count,
    input logic          rx_full,
    input logic          rx_empty,
    input logic          rx_overrun,
    input logic          rx_level,
    input logic          rx_req,
    input logic          tx_full,
    input logic          tx_empty,
    input logic          tx_room,
    input logic          tx_req
);
    a_r2_rx_bound: assert property (@(posedge clk) disable iff (rst)
        int'(rx_count) <= DEPTH);

    a_r2_rx_step: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> (int'(rx_count) <= int'($past(rx_count)) + 1) &&
                    (int'(rx_count) + 1 >= int'($past(rx_count))));

    a_r3_overrun_hold: assert property (@(posedge clk) disable iff (rst)
        rx_overrun && !cfg_wr |=> rx_overrun);

    a_r3_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_char_valid && rx_full && !rx_pop));

    a_r6_rx_req_gated: assert property (@(posedge clk) disable iff (rst)
        rx_req |-> rx_level);

    a_r5_tx_full_blocks: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> !tx_room && !tx_req);

    a_r7_rx_clear: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && cfg_wdata[1] |=> rx_empty && !rx_overrun);

    a_r7_tx_clear: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && cfg_wdata[2] |=> tx_empty);
endmodule

bind uart_fifo_ctrl uart_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .rx_char_valid (rx_char_valid),
    .rx_pop        (rx_pop),
    .rx_count      (rx_count),
    .rx_full       (rx_full),
    .rx_empty      (rx_empty),
    .rx_overrun    (rx_overrun),
    .rx_level      (rx_level),
    .rx_req        (rx_req),
    .tx_full       (tx_full),
    .tx_empty      (tx_empty),
    .tx_room       (tx_room),
    .tx_req        (tx_req)
);

// File: tb/sim_uart_fifo_ctrl.sv
module sim_uart_fifo_ctrl;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_char_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic [4:0] rx_count;
    logic       rx_empty, rx_full, rx_overrun, rx_level, rx_req;
    logic       tx_push = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_data;
    logic [4:0] tx_count;
    logic       tx_empty, tx_full, tx_room, tx_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Scoreboard state
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    int cap = DEPTH;
    bit exp_ovr = 0;

    always #10 clk = ~clk;

    uart_fifo_ctrl u0 (.*);

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        cfg_wr = 0; rx_char_valid = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1; cfg_wdata = v;
        if (v[1] || v[0] != (cap == DEPTH)) begin rxq.delete(); exp_ovr = 0; end
        if (v[2] || v[0] != (cap == DEPTH)) txq.delete();
        cap = v[0] ? DEPTH : 1;
        cycle();
    endtask

    task automatic rx_in(input logic [7:0] c);
        @(negedge clk);
        rx_char_valid = 1; rx_char = c;
        if (rxq.size() < cap) rxq.push_back(c); else exp_ovr = 1;
        cycle();
    endtask

    task automatic rx_rd(input string tag);
        @(negedge clk);
        chk(rx_data, rxq.pop_front(), tag);
        rx_pop = 1;
        cycle();
    endtask

    task automatic rx_both(input logic [7:0] c, input string tag);
        @(negedge clk);
        chk(rx_data, rxq.pop_front(), tag);
        rx_pop = 1; rx_char_valid = 1; rx_char = c;
        rxq.push_back(c);
        cycle();
    endtask

    task automatic tx_in(input logic [7:0] c);
        @(negedge clk);
        tx_push = 1; tx_wdata = c;
        if (txq.size() < cap) txq.push_back(c);
        cycle();
    endtask

    task automatic tx_rd(input string tag);
        @(negedge clk);
        chk(tx_data, txq.pop_front(), tag);
        tx_pop = 1;
        cycle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(rx_empty, 1, "R1 rx_empty");
        chk(tx_empty, 1, "R1 tx_empty");
        chk(rx_count, 0, "R1 rx_count");
        chk(rx_overrun, 0, "R1 overrun");
        chk(rx_req, 0, "R1 rx_req");
        chk(tx_req, 0, "R1 tx_req");
        chk(tx_room, 1, "R5 tx_room at reset");
        cap = 1;

        // enable, request service, threshold code 1 (4 entries)
        wr_cfg(8'h49);
        for (int i = 0; i < 3; i++) rx_in(8'h10 + 8'(i));
        chk(rx_level, 0, "R4 code1 at 3");
        rx_in(8'h13);
        chk(rx_level, 1, "R4 code1 at 4");
        chk(rx_req, 1, "R6 rx_req on");
        for (int i = 4; i < 16; i++) rx_in(8'h10 + 8'(i));
        chk(rx_full, 1, "R2 full at 16");
        chk(rx_count, 16, "R2 count 16");
        chk(tx_req, 1, "R6 tx_req on");
        rx_in(8'hEE);
        chk(rx_overrun, exp_ovr, "R3 overrun set");
        chk(rx_count, 16, "R3 count kept");
        for (int i = 0; i < 16; i++) rx_rd("R2 order");
        chk(rx_empty, 1, "R2 drained");
        chk(rx_overrun, 1, "R3 sticky");

        // R11: bits [5:4] ignored, no flush; code 3 (14 entries)
        wr_cfg(8'hF9);
        for (int i = 0; i < 13; i++) rx_in(8'h40 + 8'(i));
        chk(rx_level, 0, "R4 code3 at 13");
        rx_in(8'h4D);
        chk(rx_level, 1, "R4 code3 at 14");
        wr_cfg(8'h89);
        chk(rx_count, 14, "R11 no flush");
        for (int i = 0; i < 7; i++) rx_rd("R2 order code2");
        chk(rx_level, 0, "R4 code2 at 7");
        wr_cfg(8'h09);
        chk(rx_level, 1, "R4 code0 at 7");

        // R7 / R8 clears
        tx_in(8'hA1); tx_in(8'hA2);
        wr_cfg(8'h0B);
        chk(rx_empty, 1, "R7 rx cleared");
        chk(rx_overrun, 0, "R7 overrun cleared");
        chk(tx_count, 2, "R7 tx kept");
        rx_in(8'h77);
        chk(rx_count, 1, "R8 push after clear kept");
        wr_cfg(8'h0D);
        chk(tx_empty, 1, "R7 tx cleared");
        chk(rx_count, 1, "R7 rx kept");

        // R5 transmit room
        for (int i = 0; i < 16; i++) tx_in(8'hB0 + 8'(i));
        chk(tx_full, 1, "R2 tx full");
        chk(tx_room, 0, "R5 room low");
        chk(tx_req, 0, "R5 tx_req low");
        tx_rd("R2 tx order");
        tx_rd("R2 tx order");
        chk(tx_room, 1, "R5 room back");

        // R6 polled service
        wr_cfg(8'h01);
        chk(rx_level, 1, "R6 level still high");
        chk(rx_req, 0, "R6 rx_req gated");
        chk(tx_req, 0, "R6 tx_req gated");

        // R10 simultaneous push and pop when full
        for (int i = 1; i < 16; i++) rx_in(8'h80 + 8'(i));
        chk(rx_full, 1, "R10 full");
        rx_both(8'hC5, "R10 head");
        chk(rx_count, 16, "R10 count");
        chk(rx_overrun, 0, "R10 no overrun");
        for (int i = 0; i < 16; i++) rx_rd("R10 order");

        // R9 single holding register
        tx_in(8'hD0);
        rx_in(8'hD1);
        wr_cfg(8'h00);
        chk(rx_empty, 1, "R9 rx flushed");
        chk(tx_empty, 1, "R9 tx flushed");
        rx_in(8'h5A);
        chk(rx_full, 1, "R9 full at one");
        chk(rx_level, 1, "R9 level at one");
        rx_in(8'h5B);
        chk(rx_overrun, 1, "R9 overrun");
        chk(rx_count, 1, "R9 count one");
        rx_rd("R9 first kept");
        tx_in(8'hE0);
        chk(tx_full, 1, "R9 tx full at one");
        tx_rd("R9 tx data");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule